// File: doc/BRIEF.md
# USB Interrupt Status and Mask Unit

This block sits between a low-speed USB device's serial engine and the CPU. It turns single-cycle event strobes from the engine into sticky bits of an 8-bit status register. Each bit stays set until software clears it. An 8-bit mask register selects which latched events may raise the main interrupt request, and a global interrupt-disable input can hold that request off entirely.

The end-suspend event has its own wake-up output, which ignores the mask and the disable input. A bus-reset strobe also produces a one-cycle pulse that the neighbouring logic uses to reset the device address and the endpoint registers.

If an error or start-of-frame event arrives while the previous one of the same kind is still pending, a dedicated overrun bit records the loss. Software clears status bits by writing 0 to them. Bits written as 1 keep their value, so a store of a single constant clears exactly the intended events.

Top module: `usb_irq_unit`

## Requirements
- R1: Each event strobe sets its status bit at the next clock edge. The bit positions are: bit 7 suspend, bit 6 data overrun, bit 5 correct transfer, bit 4 error, bit 2 end-suspend, bit 1 bus reset, bit 0 start-of-frame.
- R2: A write to the status register (address 0) clears each bit written as 0 and leaves each bit written as 1 unchanged. A write never sets a bit.
- R3: When an event strobe and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R4: Status bit 3 (interrupt overrun) is set when an error strobe arrives while bit 4 reads 1, or when a start-of-frame strobe arrives while bit 0 reads 1. It is not set otherwise.
- R5: The mask register (address 1) is read/write. It uses the same bit positions as the status register.
- R6: `irq_req` is 1 exactly when some bit is 1 in both the status register and the mask register and `irq_disable` is 0. It is valid in the cycle after the edge that updated either register.
- R7: `wake_req` equals status bit 2, regardless of the mask and of `irq_disable`.
- R8: `regs_rst_pulse` is high for exactly the cycle after each clock edge that samples `ev_bus_reset` high.
- R9: A synchronous active-high `rst` clears the status register, the mask register, `rdata` and `regs_rst_pulse`.
- R10: A read with `rd_en` loads `rdata` at the next edge with the addressed register as it was before that edge. Addresses 2 and 3 read as 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address (0 status, 1 mask) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ev_suspend | input | 1 | Suspend detected strobe |
| ev_data_ovr | input | 1 | Data overrun strobe |
| ev_xfer_ok | input | 1 | Correct transfer strobe |
| ev_error | input | 1 | Timeout/CRC/stuffing/framing error strobe |
| ev_end_susp | input | 1 | Bus activity during suspend strobe |
| ev_bus_reset | input | 1 | Bus reset detected strobe |
| ev_sof | input | 1 | Keep-alive or resume-end strobe |
| irq_disable | input | 1 | Global interrupt disable |
| irq_req | output | 1 | Main interrupt request |
| wake_req | output | 1 | Wake-up request |
| regs_rst_pulse | output | 1 | Reset pulse for address and endpoint registers |

## Verification
Every register result is due one clock edge after its stimulus. A status or mask update shows on `irq_req` and `wake_req` right after the edge that latched it. `regs_rst_pulse` follows the strobe by one edge, and `rdata` holds the value from before the read edge. The bench drives every stimulus on the falling edge and advances a reference model of both registers at the rising edge. It compares all outputs at the following falling edge, so each comparison lands exactly one register stage after its cause. Sweeping all 256 mask values over several status patterns, with the disable input both low and high, covers the interrupt condition completely.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    localparam int unsigned REG_W     = 8;
    localparam int unsigned BIT_SUSP  = 7;
    localparam int unsigned BIT_DOVR  = 6;
    localparam int unsigned BIT_CTR   = 5;
    localparam int unsigned BIT_ERR   = 4;
    localparam int unsigned BIT_IOVR  = 3;
    localparam int unsigned BIT_ESUSP = 2;
    localparam int unsigned BIT_BRST  = 1;
    localparam int unsigned BIT_SOF   = 0;

    // Field order is the register layout, MSB first.
    typedef struct packed {
        logic susp;
        logic dovr;
        logic ctr;
        logic err;
        logic iovr;
        logic esusp;
        logic brst;
        logic sof;
    } irq_vec_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_MASK = 2'd2
    } reg_sel_e;

    // Write-zero-to-clear: bits written as 1 keep their value.
    function automatic irq_vec_t clear_by_zero(irq_vec_t cur, logic [REG_W-1:0] wd, logic en);
        return en ? irq_vec_t'(cur & wd) : cur;
    endfunction

endpackage

// File: rtl/usb_irq_status.sv
module usb_irq_status
    import usb_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  irq_vec_t         evt,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_data,
    output irq_vec_t         stat
);

    irq_vec_t set_v;
    irq_vec_t stat_n;
    logic     ovr_hit;

    always_comb begin
        ovr_hit    = (evt.err & stat.err) | (evt.sof & stat.sof);
        set_v      = evt;
        set_v.iovr = ovr_hit;
        // Hardware set applied after the clear: set wins.
        stat_n     = irq_vec_t'(clear_by_zero(stat, clr_data, clr_en) | set_v);
    end

    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= stat_n;
    end

    assert_err_set_R1: assert property (@(posedge clk) disable iff (rst)
        evt.err |=> stat.err);
    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !clr_data[BIT_SOF] && !evt.sof) |=> !stat.sof);
    assert_keep_one_R2: assert property (@(posedge clk) disable iff (rst)
        (clr_en && clr_data[BIT_SUSP] && stat.susp) |=> stat.susp);
    assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !clr_data[BIT_CTR] && evt.ctr) |=> stat.ctr);
    assert_overrun_R4: assert property (@(posedge clk) disable iff (rst)
        (evt.sof && stat.sof) |=> stat.iovr);

endmodule

// File: rtl/usb_irq_mask.sv
module usb_irq_mask
    import usb_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] mask
);

    always_ff @(posedge clk) begin
        if (rst)        mask <= '0;
        else if (wr_en) mask <= wdata;
    end

    assert_mask_reset_R9: assert property (@(posedge clk)
        rst |=> (mask == '0));
    assert_mask_write_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mask == $past(wdata)));

endmodule

// File: rtl/usb_irq_reqgen.sv
module usb_irq_reqgen
    import usb_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  irq_vec_t         stat,
    input  logic [REG_W-1:0] mask,
    input  logic             gdis,
    input  logic             brst_evt,
    output logic             irq_req,
    output logic             wake_req,
    output logic             regs_rst_pulse
);

    logic [REG_W-1:0] stat_v;
    logic [REG_W-1:0] hit;

    assign stat_v = stat;

    for (genvar i = 0; i < REG_W; i++) begin : g_hit
        assign hit[i] = stat_v[i] & mask[i];
    end

    assign irq_req  = (|hit) & ~gdis;
    assign wake_req = stat.esusp;

    always_ff @(posedge clk) begin
        if (rst) regs_rst_pulse <= 1'b0;
        else     regs_rst_pulse <= brst_evt;
    end

    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (rst)
        gdis |-> !irq_req);
    assert_pulse_on_R8: assert property (@(posedge clk) disable iff (rst)
        brst_evt |=> regs_rst_pulse);
    assert_pulse_off_R8: assert property (@(posedge clk) disable iff (rst)
        !brst_evt |=> !regs_rst_pulse);

endmodule

// File: rtl/usb_irq_unit.sv
module usb_irq_unit
    import usb_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              ev_suspend,
    input  logic              ev_data_ovr,
    input  logic              ev_xfer_ok,
    input  logic              ev_error,
    input  logic              ev_end_susp,
    input  logic              ev_bus_reset,
    input  logic              ev_sof,
    input  logic              irq_disable,
    output logic              irq_req,
    output logic              wake_req,
    output logic              regs_rst_pulse
);

    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(1);

    reg_sel_e         sel;
    irq_vec_t         evt;
    irq_vec_t         stat;
    logic [REG_W-1:0] mask;
    logic [REG_W-1:0] rd_mux;

    always_comb begin
        if (addr == STAT_ADDR)      sel = SEL_STAT;
        else if (addr == MASK_ADDR) sel = SEL_MASK;
        else                        sel = SEL_NONE;
    end

    always_comb begin
        evt       = '0;
        evt.susp  = ev_suspend;
        evt.dovr  = ev_data_ovr;
        evt.ctr   = ev_xfer_ok;
        evt.err   = ev_error;
        evt.esusp = ev_end_susp;
        evt.brst  = ev_bus_reset;
        evt.sof   = ev_sof;
    end

    usb_irq_status u_status (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .clr_en   (wr_en && (sel == SEL_STAT)),
        .clr_data (wdata),
        .stat     (stat)
    );

    usb_irq_mask u_mask (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en && (sel == SEL_MASK)),
        .wdata (wdata),
        .mask  (mask)
    );

    usb_irq_reqgen u_reqgen (
        .clk            (clk),
        .rst            (rst),
        .stat           (stat),
        .mask           (mask),
        .gdis           (irq_disable),
        .brst_evt       (ev_bus_reset),
        .irq_req        (irq_req),
        .wake_req       (wake_req),
        .regs_rst_pulse (regs_rst_pulse)
    );

    always_comb begin
        unique case (sel)
            SEL_STAT: rd_mux = stat;
            SEL_MASK: rd_mux = mask;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (sel == SEL_NONE)) |=> (rdata == '0));
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

endmodule

// File: tb/usb_irq_unit_tb.sv
module usb_irq_unit_tb;

    localparam time CLK_HALF = 2ns;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en, rd_en;
    logic [1:0] addr;
    logic [7:0] wdata, rdata;
    logic [7:0] ev;
    logic       gdis;
    logic       irq_req, wake_req, regs_rst_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] m_st, m_mask, m_rd;
    logic       m_pulse;

    always #CLK_HALF clk = ~clk;

    usb_irq_unit u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata),
        .ev_suspend(ev[7]), .ev_data_ovr(ev[6]), .ev_xfer_ok(ev[5]),
        .ev_error(ev[4]), .ev_end_susp(ev[2]), .ev_bus_reset(ev[1]),
        .ev_sof(ev[0]), .irq_disable(gdis),
        .irq_req(irq_req), .wake_req(wake_req), .regs_rst_pulse(regs_rst_pulse)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Outputs derived from the register model (R6, R7, R8).
    task automatic chk_outs();
        chk("R6 irq_req", {7'd0, irq_req}, {7'd0, (|(m_st & m_mask)) & ~gdis});
        chk("R7 wake_req", {7'd0, wake_req}, {7'd0, m_st[2]});
        chk("R8 regs_rst_pulse", {7'd0, regs_rst_pulse}, {7'd0, m_pulse});
    endtask

    // Drive at negedge, model update at posedge, check at next negedge.
    task automatic step(input logic [7:0] e, input logic we, input logic [1:0] a,
                        input logic [7:0] wd, input logic re);
        logic [7:0] clr;
        logic       ovr;
        ev = e; wr_en = we; addr = a; wdata = wd; rd_en = re;
        @(posedge clk);
        if (re) m_rd = (a == 2'd0) ? m_st : (a == 2'd1) ? m_mask : 8'h00;
        ovr  = (e[4] & m_st[4]) | (e[0] & m_st[0]);
        clr  = (we && a == 2'd0) ? wd : 8'hFF;
        m_st = (m_st & clr) | (e & 8'hF7) | {4'd0, ovr, 3'd0};
        if (we && a == 2'd1) m_mask = wd;
        m_pulse = e[1];
        @(negedge clk);
        ev = '0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0; addr = '0;
        chk_outs();
    endtask

    task automatic rd(input logic [1:0] a, input string req);
        step(8'h00, 1'b0, a, 8'h00, 1'b1);
        chk(req, rdata, m_rd);
    endtask

    initial begin
        #(CLK_HALF * 2 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; ev = '0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0; gdis = 0;
        m_st = '0; m_mask = '0; m_rd = '0; m_pulse = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        chk("R9 rdata", rdata, 8'h00);
        chk_outs();
        rd(2'd0, "R9 status");
        rd(2'd1, "R9 mask");

        // R1 and R2: each event alone, then cleared by writing zero to it
        for (int i = 0; i < 8; i++) begin
            if (i == 3) continue;
            step(8'(1 << i), 1'b0, 2'd0, 8'h00, 1'b0);
            rd(2'd0, "R1 event bit");
            step(8'h00, 1'b1, 2'd0, ~8'(1 << i), 1'b0);
            rd(2'd0, "R2 clear bit");
        end

        // R2: writing ones leaves bits alone, and never sets any
        step(8'hF7, 1'b0, 2'd0, 8'h00, 1'b0);
        step(8'h00, 1'b1, 2'd0, 8'hFF, 1'b0);
        rd(2'd0, "R2 ones untouched");
        step(8'h00, 1'b1, 2'd0, 8'h0F, 1'b0);
        rd(2'd0, "R2 upper cleared");
        step(8'h00, 1'b1, 2'd0, 8'h00, 1'b0);
        step(8'h00, 1'b1, 2'd0, 8'hFF, 1'b0);
        rd(2'd0, "R2 write never sets");

        // R3: set and clear in one cycle
        step(8'h10, 1'b1, 2'd0, 8'h00, 1'b0);
        rd(2'd0, "R3 set wins");
        step(8'h25, 1'b1, 2'd0, 8'h00, 1'b0);
        rd(2'd0, "R3 set wins multi");

        // R4: overrun on repeated error or start-of-frame
        step(8'h00, 1'b1, 2'd0, 8'h00, 1'b0);
        step(8'h01, 1'b0, 2'd0, 8'h00, 1'b0);
        rd(2'd0, "R4 single sof no overrun");
        step(8'h01, 1'b0, 2'd0, 8'h00, 1'b0);
        rd(2'd0, "R4 sof overrun");
        step(8'h00, 1'b1, 2'd0, 8'h00, 1'b0);
        step(8'h10, 1'b0, 2'd0, 8'h00, 1'b0);
        step(8'h00, 1'b1, 2'd0, 8'hEF, 1'b0);
        step(8'h10, 1'b0, 2'd0, 8'h00, 1'b0);
        rd(2'd0, "R4 no overrun after clear");
        step(8'h10, 1'b0, 2'd0, 8'h00, 1'b0);
        rd(2'd0, "R4 error overrun");
        step(8'h80, 1'b0, 2'd0, 8'h00, 1'b0);
        step(8'h80, 1'b0, 2'd0, 8'h00, 1'b0);
        step(8'h00, 1'b1, 2'd0, 8'hF7, 1'b0);
        step(8'h80, 1'b0, 2'd0, 8'h00, 1'b0);
        rd(2'd0, "R4 other bits no overrun");

        // R10: unmapped addresses
        step(8'h00, 1'b1, 2'd1, 8'h5A, 1'b0);
        step(8'h00, 1'b1, 2'd2, 8'hFF, 1'b0);
        step(8'h00, 1'b1, 2'd3, 8'hFF, 1'b0);
        rd(2'd2, "R10 unmapped read");
        rd(2'd3, "R10 unmapped read");
        rd(2'd1, "R10 mask unchanged");

        // R8: back-to-back bus reset strobes
        step(8'h02, 1'b0, 2'd0, 8'h00, 1'b0);
        step(8'h02, 1'b0, 2'd0, 8'h00, 1'b0);
        step(8'h00, 1'b0, 2'd0, 8'h00, 1'b0);

        // R7: wake output ignores mask and disable
        gdis = 1'b1;
        step(8'h00, 1'b1, 2'd1, 8'h00, 1'b0);
        step(8'h04, 1'b0, 2'd0, 8'h00, 1'b0);
        step(8'h00, 1'b1, 2'd0, 8'hFB, 1'b0);
        gdis = 1'b0;

        // R5 and R6: full mask sweep over several status patterns
        foreach (m_rd[k]) begin end
        for (int p = 0; p < 5; p++) begin
            logic [7:0] pat;
            pat = (p == 0) ? 8'h01 : (p == 1) ? 8'h80 : (p == 2) ? 8'hA5 :
                  (p == 3) ? 8'h00 : 8'hF7;
            step(8'h00, 1'b1, 2'd0, 8'h00, 1'b0);
            step(pat, 1'b0, 2'd0, 8'h00, 1'b0);
            if (p == 4) step(8'h11, 1'b0, 2'd0, 8'h00, 1'b0);
            for (int m = 0; m < 256; m++) begin
                gdis = 1'b0;
                step(8'h00, 1'b1, 2'd1, 8'(m), 1'b0);
                if ((m % 16) == 0) rd(2'd1, "R5 mask readback");
                gdis = 1'b1;
                #1;
                chk_outs();
            end
        end
        gdis = 1'b0;

        // R9: reset clears both registers and the pulse
        step(8'h02, 1'b1, 2'd1, 8'hFF, 1'b0);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_st = '0; m_mask = '0; m_pulse = 1'b0;
        chk("R9 rdata after reset", rdata, 8'h00);
        chk_outs();
        rd(2'd0, "R9 status after reset");
        rd(2'd1, "R9 mask after reset");

        finish_run();
    end

endmodule